// File: doc/BRIEF.md
# Store Buffer Commit Gate

This block holds retired stores of one core in a first-in, first-out queue and releases them one at a time into the L1 data cache write port. Writing into the cache is the moment a store becomes visible to the other cores; before that a retired store only sits in the queue, and a pipeline flush cannot touch it.

Before the oldest store is released, its cache-line address is compared against every outstanding entry of the load buffer. If no pending load touches that line, the store goes to the cache at once, even when older loads are still waiting for data from other lines. Stores can therefore become visible ahead of older loads, which is load-then-store reordering. If a pending load does touch the line, the store is held and a read-for-ownership request is raised for that line. When ownership arrives, the incoming fill word goes to every waiting load on the line in that same cycle. The held store is released no earlier than the next cycle, so those loads see the value from before the store.

Top module: `sb_commit_gate`

## Requirements
- R1: After reset the queue is empty: `st_ready_o` is 1, and `wr_valid_o`, `rfo_req_o` and `fwd_valid_o` are 0.
- R2: A store is taken in on a clock edge where `st_valid_i` and `st_ready_o` are both 1. `st_ready_o` is 0 exactly while DEPTH stores are held, and a store offered in that state is dropped.
- R3: Stores leave in arrival order, at most one per cycle. A store leaves only on an edge where `wr_valid_o` and `wr_grant_i` are both 1, and it carries its own address and data on `wr_addr_o`/`wr_data_o`. While the grant is low, the presented store does not change.
- R4: The oldest store overlaps a load when some bit k of `lb_valid_i` is set and field k of `lb_line_i` (bits k*LN_W upward) equals bits [ADDR_W-1:6] of the store address. Lines are 64 bytes.
- R5: If the oldest store overlaps no pending load, `wr_valid_o` is 1, even while other loads on different lines are pending.
- R6: If the oldest store overlaps a pending load and ownership has not yet arrived, `wr_valid_o` is 0, `rfo_req_o` is 1 and `rfo_line_o` carries the store's line.
- R7: In a cycle where `own_valid_i` is 1 and `own_line_i` equals the line of a held store, `fwd_valid_o` is 1, `fwd_data_o` equals `own_data_i`, and bit k of `fwd_mask_o` is set for every pending load k on that line. An ownership event for any other line forwards nothing and does not release the store.
- R8: A held store is not offered to the cache in its forwarding cycle. It is offered in the next cycle, whether or not the loads are still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Retiring store offered |
| st_addr_i | input | ADDR_W | Store byte address |
| st_data_i | input | DATA_W | Store data |
| st_ready_o | output | 1 | Queue can take a store |
| lb_valid_i | input | LB_N | Pending load-buffer entries |
| lb_line_i | input | LB_N*LN_W | Line address of each load entry |
| rfo_req_o | output | 1 | Ownership wanted for the held line |
| rfo_line_o | output | LN_W | Line wanted |
| own_valid_i | input | 1 | Ownership and fill arrived |
| own_line_i | input | LN_W | Line of the arriving fill |
| own_data_i | input | DATA_W | Fill word |
| fwd_valid_o | output | 1 | Fill forwarded to loads |
| fwd_mask_o | output | LB_N | Load entries receiving the fill |
| fwd_data_o | output | DATA_W | Forwarded fill word |
| wr_valid_o | output | 1 | Oldest store offered to the cache |
| wr_grant_i | input | 1 | Cache accepts the write |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |

## Verification
The bench builds the block with a four-entry queue and four load-buffer entries. With so few entries, backpressure is reached after a handful of stores, and a dropped store shows up as a stray write. The fill mask is also small enough to compare as a whole. Two loads sit on one line while a third is on another line, so the bench can check in one run that stores on other lines go out ahead of waiting loads, that a held store blocks the younger store behind it, and that ownership events for the wrong line have no effect.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    HD_EMPTY,
    HD_FREE,
    HD_HELD,
    HD_OWNED
  } head_st_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int unsigned WIDTH = 96,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sb_line_probe.sv
module sb_line_probe #(
  parameter int unsigned LN_W = 26,
  parameter int unsigned LB_N = 8
) (
  input  logic [LN_W-1:0]      head_line_i,
  input  logic [LN_W-1:0]      own_line_i,
  input  logic [LB_N-1:0]      lb_valid_i,
  input  logic [LB_N*LN_W-1:0] lb_line_i,
  output logic                 head_hit_o,
  output logic [LB_N-1:0]      own_mask_o
);
  logic [LB_N-1:0] head_match;

  for (genvar k = 0; k < LB_N; k++) begin : g_cmp
    logic [LN_W-1:0] ln;
    assign ln             = lb_line_i[k*LN_W +: LN_W];
    assign head_match[k]  = lb_valid_i[k] && (ln == head_line_i);
    assign own_mask_o[k]  = lb_valid_i[k] && (ln == own_line_i);
  end

  assign head_hit_o = |head_match;
endmodule

// File: rtl/sb_commit_ctrl.sv
module sb_commit_ctrl
  import sb_pkg::*;
#(
  parameter int unsigned LN_W = 26
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            head_valid_i,
  input  logic            head_hit_i,
  input  logic [LN_W-1:0] head_line_i,
  input  logic            own_valid_i,
  input  logic [LN_W-1:0] own_line_i,
  input  logic            wr_grant_i,
  output logic            wr_valid_o,
  output logic            pop_o,
  output logic            rfo_req_o,
  output logic            fwd_valid_o
);
  head_st_e st;
  logic     owned_q;

  always_comb begin
    if (!head_valid_i)   st = HD_EMPTY;
    else if (owned_q)    st = HD_OWNED;
    else if (head_hit_i) st = HD_HELD;
    else                 st = HD_FREE;
  end

  assign wr_valid_o  = (st == HD_FREE) || (st == HD_OWNED);
  assign rfo_req_o   = (st == HD_HELD);
  // fill for the held line: forward now, release next cycle
  assign fwd_valid_o = (st == HD_HELD) && own_valid_i && (own_line_i == head_line_i);
  assign pop_o       = wr_valid_o && wr_grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    owned_q <= 1'b0;
    else if (pop_o || !head_valid_i) owned_q <= 1'b0;
    else if (fwd_valid_o)           owned_q <= 1'b1;
  end
endmodule

// File: rtl/sb_commit_gate.sv
module sb_commit_gate #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned LB_N       = 8,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LN_W      = ADDR_W - OFF_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 st_valid_i,
  input  logic [ADDR_W-1:0]    st_addr_i,
  input  logic [DATA_W-1:0]    st_data_i,
  output logic                 st_ready_o,
  input  logic [LB_N-1:0]      lb_valid_i,
  input  logic [LB_N*LN_W-1:0] lb_line_i,
  output logic                 rfo_req_o,
  output logic [LN_W-1:0]      rfo_line_o,
  input  logic                 own_valid_i,
  input  logic [LN_W-1:0]      own_line_i,
  input  logic [DATA_W-1:0]    own_data_i,
  output logic                 fwd_valid_o,
  output logic [LB_N-1:0]      fwd_mask_o,
  output logic [DATA_W-1:0]    fwd_data_o,
  output logic                 wr_valid_o,
  input  logic                 wr_grant_i,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [DATA_W-1:0]    wr_data_o
);
  localparam int unsigned ENT_W = ADDR_W + DATA_W;

  logic [ENT_W-1:0]  head_ent;
  logic [ADDR_W-1:0] head_addr;
  logic [LN_W-1:0]   head_line;
  logic              empty, full, pop, head_hit;
  logic [LB_N-1:0]   own_mask;

  sb_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (st_valid_i),
    .din_i   ({st_addr_i, st_data_i}),
    .pop_i   (pop),
    .dout_o  (head_ent),
    .empty_o (empty),
    .full_o  (full)
  );

  assign head_addr = head_ent[ENT_W-1 -: ADDR_W];
  assign head_line = head_addr[ADDR_W-1:OFF_W];

  sb_line_probe #(.LN_W(LN_W), .LB_N(LB_N)) u_probe (
    .head_line_i (head_line),
    .own_line_i  (own_line_i),
    .lb_valid_i  (lb_valid_i),
    .lb_line_i   (lb_line_i),
    .head_hit_o  (head_hit),
    .own_mask_o  (own_mask)
  );

  sb_commit_ctrl #(.LN_W(LN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_valid_i (!empty),
    .head_hit_i   (head_hit),
    .head_line_i  (head_line),
    .own_valid_i  (own_valid_i),
    .own_line_i   (own_line_i),
    .wr_grant_i   (wr_grant_i),
    .wr_valid_o   (wr_valid_o),
    .pop_o        (pop),
    .rfo_req_o    (rfo_req_o),
    .fwd_valid_o  (fwd_valid_o)
  );

  assign st_ready_o = !full;
  assign rfo_line_o = rfo_req_o ? head_line : '0;
  assign fwd_mask_o = fwd_valid_o ? own_mask : '0;
  assign fwd_data_o = fwd_valid_o ? own_data_i : '0;
  assign wr_addr_o  = head_addr;
  assign wr_data_o  = head_ent[DATA_W-1:0];
endmodule

// File: rtl/sb_commit_gate_chk.sv
module sb_commit_gate_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LB_N   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LB_N-1:0]   lb_valid_i,
  input logic              rfo_req_o,
  input logic              own_valid_i,
  input logic [DATA_W-1:0] own_data_i,
  input logic              fwd_valid_o,
  input logic [LB_N-1:0]   fwd_mask_o,
  input logic [DATA_W-1:0] fwd_data_o,
  input logic              wr_valid_o,
  input logic              wr_grant_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);
  a_r3_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_grant_i |=> $stable(wr_addr_o) && $stable(wr_data_o));

  a_r6_rfo_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfo_req_o |-> !wr_valid_o);

  a_r7_fwd_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> own_valid_i && (fwd_data_o == own_data_i));

  a_r7_fwd_mask_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (fwd_mask_o != '0) && ((fwd_mask_o & ~lb_valid_i) == '0));

  a_r7_mask_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_valid_o |-> (fwd_mask_o == '0));

  a_r8_no_write_in_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> !wr_valid_o);

  a_r8_write_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |=> wr_valid_o);
endmodule

bind sb_commit_gate sb_commit_gate_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LB_N   (LB_N)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lb_valid_i  (lb_valid_i),
  .rfo_req_o   (rfo_req_o),
  .own_valid_i (own_valid_i),
  .own_data_i  (own_data_i),
  .fwd_valid_o (fwd_valid_o),
  .fwd_mask_o  (fwd_mask_o),
  .fwd_data_o  (fwd_data_o),
  .wr_valid_o  (wr_valid_o),
  .wr_grant_i  (wr_grant_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o)
);

// File: tb/sb_commit_gate_tb.sv
module sb_commit_gate_tb;
  localparam int unsigned AW = 32, DW = 64, DEPTH = 4, LB_N = 4, LNW = 26;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              st_valid_i = 1'b0;
  logic [AW-1:0]     st_addr_i = '0;
  logic [DW-1:0]     st_data_i = '0;
  logic              st_ready_o;
  logic [LB_N-1:0]   lb_valid_i = '0;
  logic [LB_N*LNW-1:0] lb_line_i = '0;
  logic              rfo_req_o;
  logic [LNW-1:0]    rfo_line_o;
  logic              own_valid_i = 1'b0;
  logic [LNW-1:0]    own_line_i = '0;
  logic [DW-1:0]     own_data_i = '0;
  logic              fwd_valid_o;
  logic [LB_N-1:0]   fwd_mask_o;
  logic [DW-1:0]     fwd_data_o;
  logic              wr_valid_o;
  logic              wr_grant_i = 1'b0;
  logic [AW-1:0]     wr_addr_o;
  logic [DW-1:0]     wr_data_o;

  always #4 clk = ~clk;

  sb_commit_gate #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .LB_N(LB_N), .LINE_BYTES(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_data_i(st_data_i), .st_ready_o(st_ready_o),
    .lb_valid_i(lb_valid_i), .lb_line_i(lb_line_i),
    .rfo_req_o(rfo_req_o), .rfo_line_o(rfo_line_o),
    .own_valid_i(own_valid_i), .own_line_i(own_line_i), .own_data_i(own_data_i),
    .fwd_valid_o(fwd_valid_o), .fwd_mask_o(fwd_mask_o), .fwd_data_o(fwd_data_o),
    .wr_valid_o(wr_valid_o), .wr_grant_i(wr_grant_i), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [LNW-1:0] ln(input logic [AW-1:0] a);
    return a[AW-1:6];
  endfunction

  // scoreboard monitor: every cache write must match the oldest expected store
  always @(negedge clk) begin
    if (rst_ni && wr_valid_o && wr_grant_i) begin
      exp_t e;
      if (q.size() == 0) begin
        chk(1'b0, "R3", "write with no store pending", 64'(wr_addr_o), 64'hx);
      end else begin
        e = q.pop_front();
        chk(wr_addr_o == e.a, "R3", "write address order", 64'(wr_addr_o), 64'(e.a));
        chk(wr_data_o == e.d, "R3", "write data order", wr_data_o, e.d);
      end
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    st_valid_i = 1'b1; st_addr_i = a; st_data_i = d;
    forever begin
      @(negedge clk);
      if (st_ready_o) break;
    end
    @(posedge clk); #1;
    st_valid_i = 1'b0;
    q.push_back('{a: a, d: d});
  endtask

  task automatic set_lb(input int k, input logic [AW-1:0] a);
    lb_valid_i[k] = 1'b1;
    lb_line_i[k*LNW +: LNW] = ln(a);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    report();
  end

  initial begin
    logic [AW-1:0] held_addr;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(st_ready_o == 1'b1, "R1", "st_ready_o", 64'(st_ready_o), 64'd1);
    chk(wr_valid_o == 1'b0, "R1", "wr_valid_o", 64'(wr_valid_o), 64'd0);
    chk(rfo_req_o == 1'b0, "R1", "rfo_req_o", 64'(rfo_req_o), 64'd0);
    chk(fwd_valid_o == 1'b0, "R1", "fwd_valid_o", 64'(fwd_valid_o), 64'd0);

    // R2/R3 plain flow
    wr_grant_i = 1'b1;
    push(32'h0000_0100, 64'h1111_0000_0000_0001);
    push(32'h0000_0240, 64'h2222_0000_0000_0002);
    cyc(3);
    chk(q.size() == 0, "R3", "all stores written", 64'(q.size()), 64'd0);

    // R5: pending load on another line does not block
    set_lb(0, 32'h0000_8000);
    push(32'h0000_1000, 64'h3333_0000_0000_0003);
    @(negedge clk);
    chk(wr_valid_o == 1'b1, "R5", "store passes older load", 64'(wr_valid_o), 64'd1);
    cyc(2);

    // R4/R6: same-line load holds the store and the younger one behind it
    set_lb(1, 32'h0000_3008);
    push(32'h0000_3030, 64'h4444_0000_0000_0004);
    push(32'h0000_5000, 64'h5555_0000_0000_0005);
    cyc(2);
    @(negedge clk);
    chk(wr_valid_o == 1'b0, "R6", "held store not offered", 64'(wr_valid_o), 64'd0);
    chk(rfo_req_o == 1'b1, "R6", "rfo request", 64'(rfo_req_o), 64'd1);
    chk(rfo_line_o == ln(32'h0000_3030), "R4", "rfo line", 64'(rfo_line_o), 64'(ln(32'h0000_3030)));
    chk(q.size() == 2, "R3", "younger store waits", 64'(q.size()), 64'd2);

    // R7: ownership for an unrelated line has no effect
    @(posedge clk); #1;
    own_valid_i = 1'b1; own_line_i = ln(32'h0000_5000); own_data_i = 64'hBAD0_BAD0_BAD0_BAD0;
    @(negedge clk);
    chk(fwd_valid_o == 1'b0, "R7", "no forward on other line", 64'(fwd_valid_o), 64'd0);
    @(posedge clk); #1;
    own_valid_i = 1'b0;
    @(negedge clk);
    chk(wr_valid_o == 1'b0, "R7", "other-line event does not release", 64'(wr_valid_o), 64'd0);

    // R7/R8: matching ownership forwards, store released next cycle
    set_lb(2, 32'h0000_3010);
    @(posedge clk); #1;
    own_valid_i = 1'b1; own_line_i = ln(32'h0000_3000); own_data_i = 64'hF111_F222_F333_F444;
    @(negedge clk);
    chk(fwd_valid_o == 1'b1, "R7", "forward valid", 64'(fwd_valid_o), 64'd1);
    chk(fwd_mask_o == 4'b0110, "R7", "forward mask", 64'(fwd_mask_o), 64'h6);
    chk(fwd_data_o == 64'hF111_F222_F333_F444, "R7", "forward data", fwd_data_o, 64'hF111_F222_F333_F444);
    chk(wr_valid_o == 1'b0, "R8", "no write in forward cycle", 64'(wr_valid_o), 64'd0);
    @(posedge clk); #1;
    own_valid_i = 1'b0;
    @(negedge clk);
    chk(wr_valid_o == 1'b1, "R8", "write next cycle", 64'(wr_valid_o), 64'd1);
    chk(wr_addr_o == 32'h0000_3030, "R8", "released store", 64'(wr_addr_o), 64'h3030);
    cyc(3);
    lb_valid_i = '0;
    chk(q.size() == 0, "R3", "queue drained after release", 64'(q.size()), 64'd0);

    // R2/R3: backpressure with grant low
    wr_grant_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) push(32'h0001_0000 + 32'(i * 64), 64'(64'hA000 + i));
    @(negedge clk);
    chk(st_ready_o == 1'b0, "R2", "full backpressure", 64'(st_ready_o), 64'd0);
    chk(wr_valid_o == 1'b1, "R3", "head offered", 64'(wr_valid_o), 64'd1);
    held_addr = wr_addr_o;
    @(posedge clk); #1;
    st_valid_i = 1'b1; st_addr_i = 32'h0000_DEAD; st_data_i = 64'hDEAD;
    repeat (3) begin
      @(negedge clk);
      chk(st_ready_o == 1'b0, "R2", "still full", 64'(st_ready_o), 64'd0);
      chk(wr_addr_o == held_addr, "R3", "head stable without grant", 64'(wr_addr_o), 64'(held_addr));
    end
    @(posedge clk); #1;
    st_valid_i = 1'b0;
    wr_grant_i = 1'b1;
    cyc(8);
    chk(q.size() == 0, "R3", "drained in order", 64'(q.size()), 64'd0);
    @(negedge clk);
    chk(st_ready_o == 1'b1, "R2", "ready after drain", 64'(st_ready_o), 64'd1);
    chk(wr_valid_o == 1'b0, "R2", "dropped store not written", 64'(wr_valid_o), 64'd0);
    report();
  end
endmodule